// File: doc/BRIEF.md
# Glitch-Free Selectable Card Clock Divider

This block derives a card clock from a reference clock by dividing it by 1, 2, 4 or 8. A two-bit select input picks the ratio, and a run input from the activation sequencer starts the clock or parks it LOW. Both inputs are asynchronous to the reference and pass through synchronisers before they are used.

A free-running counter drives every divided phase, so all ratios stay aligned to one another. A change of ratio, a start or a stop is held back until a reference rising edge where the output is about to rise anyway. For a ratio change this is the edge that ends a complete period of both the old and the new ratio. As a result the last pulse before a change and the first pulse after it both have full width, and a stop always leaves the output LOW.

In divide-by-1 mode the reference itself is gated through to the output. The gate enable changes only while the reference is LOW.

Top module: `card_clk_div`

## Requirements
- R1: The ratio select decodes as 2'b00 = divide by 8, 2'b01 = divide by 4, 2'b11 = divide by 2 and 2'b10 = divide by 1.
- R2: For ratio N of 2, 4 or 8, a running output is HIGH for N/2 reference periods and LOW for N/2. It rises only on reference rising edges whose count since reset release is a multiple of N, counting the first edge after release as 1.
- R3: In divide-by-1 mode a running output equals the reference clock: HIGH in the reference HIGH phase and LOW in the reference LOW phase.
- R4: A change on run or on the ratio select, made between rising edges k-1 and k, can take effect no earlier than rising edge k+2.
- R5: A ratio change is applied only on a rising edge whose count is a multiple of the larger of the old and new ratios.
- R6: Starting is applied only on a rising edge whose count is a multiple of the current ratio. The first pulse after a start has full width.
- R7: Stopping is applied only on a rising edge whose count is a multiple of the current ratio. From that edge the output stays LOW, and the last pulse before it has full width.
- R8: While reset is asserted, and after reset until a start is applied, the output is LOW. The ratio held at reset is divide by 8, with the clock stopped.
- R9: Every HIGH pulse lasts exactly 1/2, 1, 2 or 4 reference periods, and the divided and pass-through paths are never active together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Run request from the sequencer, asynchronous |
| ratio_sel_i | input | 2 | Ratio select, asynchronous |
| clk_o | output | 1 | Divided card clock |

## Verification
A request is seen by the decision logic two rising edges after it is captured. It is applied on the first aligned edge from the third edge on. The output for that cycle then appears straight away: from the divided flop on the same rising edge, or from the pass-through enable that was loaded on the falling edge before it.

The bench models this with its own edge count and input history. It changes inputs only on falling edges. It compares the output in the middle of every HIGH half and every LOW half of the reference, so each half-cycle of every ratio, and every pending change, is checked against the cycle in which it is due.

// File: rtl/card_clk_div_pkg.sv
package card_clk_div_pkg;
  localparam int unsigned MAX_LOG2 = 3;
  localparam int unsigned CNT_W    = MAX_LOG2;
  localparam int unsigned SHIFT_W  = $clog2(MAX_LOG2 + 1);

  typedef logic [CNT_W-1:0]   cnt_t;
  typedef logic [SHIFT_W-1:0] shift_t;

  typedef enum logic [1:0] {
    SEL_DIV8 = 2'b00,
    SEL_DIV4 = 2'b01,
    SEL_DIV1 = 2'b10,
    SEL_DIV2 = 2'b11
  } ratio_sel_e;

  function automatic shift_t sel_to_shift(input logic [1:0] sel);
    case (ratio_sel_e'(sel))
      SEL_DIV8: return shift_t'(3);
      SEL_DIV4: return shift_t'(2);
      SEL_DIV2: return shift_t'(1);
      default:  return shift_t'(0);
    endcase
  endfunction

  function automatic cnt_t low_mask(input shift_t s);
    cnt_t m;
    for (int i = 0; i < int'(CNT_W); i++) m[i] = (i < int'(s));
    return m;
  endfunction

  function automatic logic phase_high(input cnt_t c, input shift_t s);
    logic r;
    r = 1'b0;
    for (int i = 0; i < int'(CNT_W); i++)
      if (int'(s) == i + 1) r = ~c[i];
    return r;
  endfunction

  function automatic shift_t shift_max(input shift_t a, input shift_t b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/card_clk_div_sync.sv
module card_clk_div_sync #(
  parameter int unsigned     WIDTH   = 1,
  parameter int unsigned     STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= {STAGES{RST_VAL}};
    else         stage_q <= {stage_q[STAGES-2:0], d_i};
  end

  assign q_o = stage_q[STAGES-1];

  initial begin
    stages_min_chk: assert (STAGES >= 2);
  end
endmodule

// File: rtl/card_clk_div_ctrl.sv
module card_clk_div_ctrl
  import card_clk_div_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_req_i,
  input  logic [1:0] sel_i,
  output logic       run_d_o,
  output shift_t     shift_d_o,
  output cnt_t       cnt_d_o,
  output logic       run_q_o,
  output shift_t     shift_q_o,
  output cnt_t       cnt_q_o
);
  localparam shift_t SHIFT_RST = shift_t'(MAX_LOG2);

  cnt_t   cnt_q;
  shift_t shift_q;
  logic   run_q;
  shift_t shift_req;
  logic   pending;
  logic   aligned;

  always_comb begin
    shift_req = sel_to_shift(sel_i);
    cnt_d_o   = cnt_q + cnt_t'(1);
    pending   = (run_req_i != run_q) || (shift_req != shift_q);
    // edge ends a full period of both old and new ratio
    aligned   = ((cnt_d_o & low_mask(shift_max(shift_q, shift_req))) == '0);
    run_d_o   = run_q;
    shift_d_o = shift_q;
    if (pending && aligned) begin
      run_d_o   = run_req_i;
      shift_d_o = shift_req;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      shift_q <= SHIFT_RST;
      run_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d_o;
      shift_q <= shift_d_o;
      run_q   <= run_d_o;
    end
  end

  assign run_q_o   = run_q;
  assign shift_q_o = shift_q;
  assign cnt_q_o   = cnt_q;

  // R5
  ratio_switch_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_q != $past(shift_q)) |->
      ((cnt_q & low_mask(shift_max(shift_q, $past(shift_q)))) == '0));

  // R6
  start_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> ((cnt_q & low_mask(shift_q)) == '0));

  // R7
  stop_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_q) |-> ((cnt_q & low_mask($past(shift_q))) == '0));
endmodule

// File: rtl/card_clk_div_out.sv
module card_clk_div_out
  import card_clk_div_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   run_d_i,
  input  shift_t shift_d_i,
  input  cnt_t   cnt_d_i,
  output logic   div_q_o,
  output logic   pass_q_o,
  output logic   clk_o
);
  logic div_d;
  logic pass_d;

  always_comb begin
    div_d  = run_d_i && (shift_d_i != '0) && phase_high(cnt_d_i, shift_d_i);
    pass_d = run_d_i && (shift_d_i == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q_o <= 1'b0;
    else         div_q_o <= div_d;
  end

  // loaded while reference is LOW, ahead of the rising edge it governs
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pass_q_o <= 1'b0;
    else         pass_q_o <= pass_d;
  end

  assign clk_o = div_q_o | (clk_i & pass_q_o);

  // R9
  paths_exclusive_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !(pass_q_o && div_q_o));
endmodule

// File: rtl/card_clk_div.sv
module card_clk_div
  import card_clk_div_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] ratio_sel_i,
  output logic       clk_o
);
  logic       run_s;
  logic [1:0] sel_s;
  logic       run_d, run_q;
  shift_t     shift_d, shift_q;
  cnt_t       cnt_d, cnt_q;
  logic       div_q, pass_q;

  card_clk_div_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_run_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (run_i),
    .q_o   (run_s)
  );

  card_clk_div_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(SEL_DIV8)) u_sel_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ratio_sel_i),
    .q_o   (sel_s)
  );

  card_clk_div_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_req_i(run_s),
    .sel_i    (sel_s),
    .run_d_o  (run_d),
    .shift_d_o(shift_d),
    .cnt_d_o  (cnt_d),
    .run_q_o  (run_q),
    .shift_q_o(shift_q),
    .cnt_q_o  (cnt_q)
  );

  card_clk_div_out u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_d_i  (run_d),
    .shift_d_i(shift_d),
    .cnt_d_i  (cnt_d),
    .div_q_o  (div_q),
    .pass_q_o (pass_q),
    .clk_o    (clk_o)
  );

  // R2
  div_rise_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div_q) |-> ((cnt_q & low_mask(shift_q)) == '0));

  // R7
  stopped_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !div_q);

  // R3
  pass_only_div1_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    pass_q |-> (run_q && (shift_q == '0)));
endmodule

// File: tb/card_clk_div_tb.sv
module card_clk_div_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       run_i = 1'b0;
  logic [1:0] sel_i = 2'b00;
  logic       clk_o;

  int    n_cmp = 0;
  int    n_bad = 0;
  string req = "R8";
  bit    done = 1'b0;

  int edge_n = 0;
  int m_run = 0;
  int m_sh = 3;
  int g_hist[$];
  int s_hist[$];
  int hi_len = 0;
  bit last_lvl = 1'b0;

  card_clk_div u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_i),
    .ratio_sel_i(sel_i),
    .clk_o      (clk_o)
  );

  always #4 clk_i = ~clk_i;

  // R1: ratio code to log2 of ratio
  function automatic int code_log2(input int code);
    case (code)
      0: return 3;
      1: return 2;
      3: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic check(input bit act, input bit exp, input string tag, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: clk_o=%0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // R9: HIGH pulses only 1, 2, 4 or 8 half periods long
  task automatic width_mon(input bit lvl);
    if (lvl) hi_len++;
    else if (last_lvl) begin
      n_cmp++;
      if (!(hi_len == 1 || hi_len == 2 || hi_len == 4 || hi_len == 8)) begin
        n_bad++;
        $display("FAIL R9 pulse width: %0d half periods expected 1/2/4/8 at %0t", hi_len, $time);
      end
      hi_len = 0;
    end
    last_lvl = lvl;
  endtask

  initial begin
    g_hist = {0, 0};
    s_hist = {0, 0};
  end

  always @(posedge clk_i) begin
    int ws, wr, mx, per, ph;
    bit eh, el;
    if (!rst_ni) begin
      #2 check(clk_o, 1'b0, "R8", "reset high half");
      #4 check(clk_o, 1'b0, "R8", "reset low half");
    end else begin
      edge_n++;
      g_hist.push_back(int'(run_i));
      s_hist.push_back(int'(sel_i));
      // R4: decision sees inputs captured two edges earlier
      wr = g_hist[g_hist.size() - 3];
      ws = code_log2(s_hist[s_hist.size() - 3]);
      mx = (ws > m_sh) ? ws : m_sh;
      if ((wr != m_run || ws != m_sh) && (edge_n % (1 << mx)) == 0) begin
        m_run = wr;
        m_sh  = ws;
      end
      per = 1 << m_sh;
      ph  = edge_n % per;
      if (m_sh == 0) begin
        eh = (m_run != 0);
        el = 1'b0;
      end else begin
        eh = (m_run != 0) && (ph < per / 2);
        el = eh;
      end
      #2;
      check(clk_o, eh, req, "high half");
      width_mon(clk_o);
      #4;
      check(clk_o, el, req, "low half");
      width_mon(clk_o);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    wait_cyc(4);
    rst_ni = 1'b1;
    req = "R8";  wait_cyc(10);
    req = "R6";  run_i = 1'b1; wait_cyc(40);
    req = "R1";  sel_i = 2'b01; wait_cyc(40);
    req = "R2";  sel_i = 2'b11; wait_cyc(40);
    req = "R3";  sel_i = 2'b10; wait_cyc(30);
    req = "R5";
    sel_i = 2'b00; wait_cyc(5);
    sel_i = 2'b11; wait_cyc(3);
    sel_i = 2'b10; wait_cyc(13);
    sel_i = 2'b01; wait_cyc(7);
    sel_i = 2'b00; wait_cyc(11);
    sel_i = 2'b10; wait_cyc(9);
    sel_i = 2'b11; wait_cyc(1);
    sel_i = 2'b01; wait_cyc(25);
    req = "R7";  run_i = 1'b0; wait_cyc(30);
    req = "R4";  sel_i = 2'b10; wait_cyc(12);
    run_i = 1'b1; wait_cyc(15);
    run_i = 1'b0; wait_cyc(1);
    run_i = 1'b1; wait_cyc(20);
    req = "R9";
    for (int i = 0; i < 12; i++) begin
      sel_i = 2'(i * 3);
      run_i = (i % 5) != 4;
      wait_cyc(3 + (i * 7) % 11);
    end
    run_i = 1'b0; wait_cyc(30);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end
endmodule